// File: doc/BRIEF.md
# I2C Slave Protocol Engine

This block is the serial front end of a register-programmed device that works only as a slave on a two-wire I2C bus. It receives the raw clock and data lines, removes short glitches, and detects start, repeated start and stop conditions. It then decides whether the address byte is meant for this device and acknowledges it. It gives a register back end a byte-level view of each transfer: one strobe carries the subaddress, one carries each write data byte, one requests the next read byte, and two pulses mark the start and the end of bus activity.

The engine only drives an open-drain enable for SDA. It never holds SCL low, so it adds no wait states. For that reason the back end must supply read data one system clock after each request. The 7-bit device address starts at 0x36. A single bus write can move it to 0x38 at run time. At a 50 MHz system clock the engine follows both 100 kHz and 400 kHz bus timing.

Top module: `i2c_slave_engine`

## Requirements
- R1: An SDA fall while SCL is high is a start. This includes a repeated start in the middle of a transfer. A start pulses `bus_start` for one cycle, releases SDA and makes the next eight bits an address byte.
- R2: An SDA rise while SCL is high is a stop. A stop pulses `bus_stop` for one cycle and returns the engine to idle with SDA released. SDA is also released out of reset.
- R3: The address byte travels most significant bit first. Bits 7..1 hold the device address and bit 0 is the direction bit (1 = read). The engine acknowledges by pulling SDA low through the high phase of the ninth clock, but only when bits 7..1 equal the current device address. That address is 0x36 after reset.
- R4: After an address that does not match, the engine leaves SDA released and gives no strobes until the next start or stop.
- R5: The first byte after a matching write address is the subaddress. It is acknowledged and reported with a one-cycle `sub_stb`, with the byte on `rx_byte`.
- R6: Each later byte of a write is acknowledged and reported with a one-cycle `wr_stb`, with the byte on `rx_byte`. There is no limit on the number of bytes.
- R7: In a read, `rd_req` pulses once after the matching read address and once after each master acknowledge. The byte on `rd_byte` in the cycle after the pulse is sent most significant bit first.
- R8: After a master not-acknowledge, the engine drives nothing and requests nothing until the next start or stop.
- R9: The first data byte written after subaddress 0xF9 changes the device address to 0x38 if its value is 0x38. Any other value leaves the address unchanged.
- R10: Both lines pass through a two-flop synchronizer. A level is accepted only after three equal samples, so an SDA pulse of two system clocks or less produces no bus event.
- R11: The SDA drive changes only while the filtered SCL is low. Transfers work at both 100 kHz and 400 kHz SCL with a 50 MHz system clock.
- R12: `bus_start`, `bus_stop`, `sub_stb`, `wr_stb` and `rd_req` each last one cycle, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | When high, pulls SDA low (open drain) |
| bus_start | output | 1 | One-cycle pulse on start or repeated start |
| bus_stop | output | 1 | One-cycle pulse on stop |
| sub_stb | output | 1 | Subaddress byte valid on rx_byte |
| wr_stb | output | 1 | Write data byte valid on rx_byte |
| rd_req | output | 1 | Request for the next read byte |
| rx_byte | output | 8 | Received byte |
| rd_byte | input | 8 | Read byte from the back end, sampled the cycle after rd_req |

## Verification
On every cycle, the assertions check the following:
- the SDA drive changes only while the filtered clock is low;
- starts and stops always leave SDA released;
- every subaddress or write strobe comes with an acknowledge;
- the strobes are single, exclusive pulses;
- the ignore state stays silent.

Other behaviours show only in the bench's scenarios: the address compare, the read data order, the run-time address change, the rejection of glitches and correct operation at both bus rates. The bench shows each of these by driving complete bus transactions as a master and checking the acknowledges and bytes seen on the wire.

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine #(
  parameter logic [6:0] RST_ADDR = 7'h36,
  parameter logic [7:0] CFG_SUB  = 8'hF9,
  parameter logic [6:0] ALT_ADDR = 7'h38
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       bus_start,
  output logic       bus_stop,
  output logic       sub_stb,
  output logic       wr_stb,
  output logic       rd_req,
  output logic [7:0] rx_byte,
  input  logic [7:0] rd_byte
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_IGN} state_t;

  state_t      state;
  logic [1:0]  scl_sy, sda_sy;
  logic [2:0]  scl_h, sda_h;
  logic        scl_f, sda_f, scl_d, sda_d;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, txbyte;
  logic [6:0]  dev_addr;
  logic        rnw, first, cfg_hit;
  logic        ignoring;

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  assign rx_byte  = shreg;
  assign ignoring = (state == S_IGN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_h  <= '1; sda_h  <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_d  <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_h  <= {scl_h[1:0], scl_sy[1]};
      sda_h  <= {sda_h[1:0], sda_sy[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txbyte    <= '0;
      dev_addr  <= RST_ADDR;
      rnw       <= 1'b0;
      first     <= 1'b0;
      cfg_hit   <= 1'b0;
      sda_oe    <= 1'b0;
      bus_start <= 1'b0;
      bus_stop  <= 1'b0;
      sub_stb   <= 1'b0;
      wr_stb    <= 1'b0;
      rd_req    <= 1'b0;
    end else begin
      bus_start <= 1'b0;
      bus_stop  <= 1'b0;
      sub_stb   <= 1'b0;
      wr_stb    <= 1'b0;
      rd_req    <= 1'b0;
      if (rd_req) txbyte <= rd_byte;

      if (start_c) begin
        state     <= S_ADDR;
        bitcnt    <= '0;
        sda_oe    <= 1'b0;
        bus_start <= 1'b1;
        first     <= 1'b1;
        cfg_hit   <= 1'b0;
      end else if (stop_c) begin
        state    <= S_IDLE;
        sda_oe   <= 1'b0;
        bus_stop <= 1'b1;
      end else if (state != S_IDLE && state != S_IGN) begin
        if (scl_rise) begin
          bitcnt <= bitcnt + 4'd1;
          if (state != S_RD && bitcnt < 4'd8) shreg <= {shreg[6:0], sda_f};
          if (state == S_RD && bitcnt == 4'd8) begin
            if (sda_f) state  <= S_IGN;
            else       rd_req <= 1'b1;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (state)
              S_ADDR: begin
                if (shreg[7:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  rnw    <= shreg[0];
                  if (shreg[0]) rd_req <= 1'b1;
                end else begin
                  state <= S_IGN;
                end
              end
              S_WR: begin
                sda_oe <= 1'b1;
                if (first) begin
                  sub_stb <= 1'b1;
                  first   <= 1'b0;
                  cfg_hit <= (shreg == CFG_SUB);
                end else begin
                  wr_stb  <= 1'b1;
                  cfg_hit <= 1'b0;
                  if (cfg_hit && shreg == {1'b0, ALT_ADDR}) dev_addr <= ALT_ADDR;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            if (state == S_RD || (state == S_ADDR && rnw)) begin
              state  <= S_RD;
              shreg  <= txbyte;
              sda_oe <= ~txbyte[7];
            end else begin
              state  <= S_WR;
              sda_oe <= 1'b0;
            end
          end else if (state == S_RD && bitcnt != 4'd0) begin
            sda_oe <= ~shreg[6];
            shreg  <= {shreg[6:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_slave_engine_chk.sv
module i2c_slave_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic bus_start,
  input logic bus_stop,
  input logic sub_stb,
  input logic wr_stb,
  input logic rd_req,
  input logic scl_f,
  input logic ignoring
);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f); // R11
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> !sda_oe); // R1
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |-> !sda_oe); // R2
  AST_SUB_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stb |-> sda_oe); // R5
  AST_WR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sda_oe); // R6
  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe && !sub_stb && !wr_stb && !rd_req); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_start, bus_stop, sub_stb, wr_stb, rd_req})); // R12
  AST_SUB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stb |=> !sub_stb); // R12
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R12
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R7

endmodule

bind i2c_slave_engine i2c_slave_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .bus_start(bus_start),
  .bus_stop(bus_stop), .sub_stb(sub_stb), .wr_stb(wr_stb), .rd_req(rd_req),
  .scl_f(scl_f), .ignoring(ignoring)
);

// File: tb/i2c_slave_engine_test.sv
module i2c_slave_engine_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, bus_start, bus_stop, sub_stb, wr_stb, rd_req;
  logic [7:0] rx_byte;
  logic [7:0] rd_data = 8'h00;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, qp = 31;
  int n_start = 0, n_stop = 0, n_sub = 0, n_wr = 0, n_rd = 0;
  logic [7:0] last_sub = 8'h00, last_wr = 8'h00;

  always #10 clk = ~clk;

  i2c_slave_engine uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .bus_start(bus_start), .bus_stop(bus_stop),
    .sub_stb(sub_stb), .wr_stb(wr_stb), .rd_req(rd_req),
    .rx_byte(rx_byte), .rd_byte(rd_data)
  );

  always @(negedge clk) begin
    if (bus_start) n_start <= n_start + 1;
    if (bus_stop)  n_stop  <= n_stop + 1;
    if (sub_stb) begin n_sub <= n_sub + 1; last_sub <= rx_byte; end
    if (wr_stb)  begin n_wr  <= n_wr + 1;  last_wr  <= rx_byte; end
    if (rd_req)  begin rd_data <= 8'hA0 + n_rd[7:0]; n_rd <= n_rd + 1; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (qp) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic bit_io(input logic b, output logic seen);
    sda_m = b; q(); scl_m = 1'b1; q(); seen = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); d[i] = s; end
    bit_io(~ack, s);
  endtask

  localparam logic [24:0] VEC [6] = '{
    {8'h6C, 8'h10, 8'h5A, 1'b1},
    {8'h70, 8'h11, 8'h33, 1'b0},
    {8'h6E, 8'h12, 8'h44, 1'b0},
    {8'h00, 8'h13, 8'h55, 1'b0},
    {8'h6C, 8'hF0, 8'hC3, 1'b1},
    {8'hEC, 8'h14, 8'h66, 1'b0}
  };

  task automatic write3(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                        output logic ka, output logic ks, output logic kd);
    start_c(); send_byte(a, ka); send_byte(s, ks); send_byte(d, kd); stop_c();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ka, ks, kd;
    logic [7:0] d;
    int b0, b1, b2, b3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 reset sda released", sda_oe, 0);
    chk("R2 reset no events", n_start + n_stop, 0);

    for (int i = 0; i < 6; i++) begin
      b0 = n_sub; b1 = n_wr; b2 = n_start; b3 = n_stop;
      write3(VEC[i][24:17], VEC[i][16:9], VEC[i][8:1], ka, ks, kd);
      chk("R3 address ack", ka, VEC[i][0]);
      chk("R1 start seen", n_start - b2, 1);
      chk("R2 stop seen", n_stop - b3, 1);
      if (VEC[i][0]) begin
        chk("R5 sub strobe", n_sub - b0, 1);
        chk("R5 sub byte", last_sub, VEC[i][16:9]);
        chk("R6 wr byte", last_wr, VEC[i][8:1]);
        chk("R6 data acked", kd, 1);
      end else begin
        chk("R4 no strobes", (n_sub - b0) + (n_wr - b1), 0);
        chk("R4 no ack", ks | kd, 0);
      end
    end

    b1 = n_wr;
    start_c(); send_byte(8'h6C, ka); send_byte(8'h20, ks);
    for (int i = 1; i <= 4; i++) begin
      send_byte(8'(i), kd);
      chk("R6 multi ack", kd, 1);
    end
    stop_c();
    chk("R6 R12 multi count", n_wr - b1, 4);
    chk("R6 multi last", last_wr, 8'h04);

    b0 = n_rd;
    start_c(); send_byte(8'h6D, ka);
    chk("R3 read addr ack", ka, 1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, d);
      chk("R7 read data", d, 8'hA0 + 8'(b0 + i));
    end
    chk("R7 request count", n_rd - b0, 3);
    recv_byte(1'b0, d);
    chk("R8 released after nack", d, 8'hFF);
    chk("R8 no request after nack", n_rd - b0, 3);
    stop_c();

    b0 = n_rd; b2 = n_start;
    start_c(); send_byte(8'h6C, ka); send_byte(8'h40, ks);
    start_c(); send_byte(8'h6D, ka);
    chk("R1 repeated start ack", ka, 1);
    recv_byte(1'b0, d); stop_c();
    chk("R1 repeated start count", n_start - b2, 2);
    chk("R1 sub before restart", last_sub, 8'h40);
    chk("R7 read after restart", d, 8'hA0 + 8'(b0));

    write3(8'h6C, 8'hF9, 8'h12, ka, ks, kd);
    start_c(); send_byte(8'h70, ka); stop_c();
    chk("R9 other value keeps address", ka, 0);
    write3(8'h6C, 8'hF9, 8'h38, ka, ks, kd);
    start_c(); send_byte(8'h6C, ka); stop_c();
    chk("R9 old address dropped", ka, 0);
    start_c(); send_byte(8'h70, ka); stop_c();
    chk("R9 new address acked", ka, 1);

    qp = 125;
    b1 = n_wr;
    write3(8'h70, 8'h55, 8'h99, ka, ks, kd);
    chk("R11 slow write acks", {ka, ks, kd}, 3'b111);
    chk("R11 slow write data", last_wr, 8'h99);
    b0 = n_rd;
    start_c(); send_byte(8'h71, ka); recv_byte(1'b0, d); stop_c();
    chk("R11 slow read data", d, 8'hA0 + 8'(b0));
    qp = 31;

    b2 = n_start; b3 = n_stop;
    repeat (20) @(negedge clk);
    sda_m = 1'b0; repeat (2) @(negedge clk); sda_m = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 glitch ignored", n_start - b2, 0);
    sda_m = 1'b0; repeat (8) @(negedge clk); sda_m = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 long pulse start", n_start - b2, 1);
    chk("R10 long pulse stop", n_stop - b3, 1);
    chk("R2 idle released", sda_oe, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule